// File: doc/BRIEF.md
# SIMT Lane-Mask Divergence Stack

This block keeps track of which lanes of a SIMD thread group are live while the group runs conditional code. It holds the current active-lane mask in a register and a small last-in-first-out store of saved masks. When a branch splits the live lanes into two non-empty groups, it saves the mask from before the branch together with the set of lanes that took the branch. It then narrows the active mask to the taking lanes. An else strobe switches the group to the lanes that did not take the branch. A converge strobe acts as the rejoin barrier: it pops the entry and restores the mask from before the branch.

Nested divergent branches stack up to the configured depth. If every live lane agrees on the condition, nothing is saved and the mask does not change. The front end is then expected to skip that branch's else and converge markers. When a divergent branch arrives with the stack already full, the block does not push. It raises a sticky overflow flag instead. In an if/else with two halves of equal length, every lane sits idle for one half, so lane utilisation is 50%. Fetch and target address logic sit outside this block.

Top module: `simt_mask_stack`

## Requirements
- R1: After a synchronous active-high reset, active_mask is all ones, stack_empty is 1, stack_full is 0 and overflow_err is 0.
- R2: A branch whose condition is 1 for some, but not all, active lanes (a divergent branch) with the stack not full has two effects one cycle later: active_mask becomes the old active_mask AND cond, and one entry is pushed.
- R3: A branch whose condition is the same for every active lane (cond AND active equals 0 or equals active) leaves active_mask unchanged and pushes nothing.
- R4: An else strobe with a non-empty stack, whose top entry has not yet been switched, sets active_mask to saved AND NOT taken. The two halves are therefore disjoint and together make up the saved mask. A second else on the same entry is ignored.
- R5: A converge strobe with a non-empty stack pops the top entry and restores active_mask to the mask that entry saved before its branch.
- R6: Divergent branches nest up to DEPTH (8) entries. stack_full is 1 exactly when DEPTH entries are held, and stack_empty is 1 exactly when none are held.
- R7: A divergent branch while stack_full is 1 pushes nothing and leaves active_mask unchanged. It also sets overflow_err, which stays 1 until reset.
- R8: Else or converge strobes that arrive while the stack is empty change nothing.
- R9: When several strobes arrive in the same cycle, only one is acted on: converge first, then else, then branch.
- R10: Outside reset, active_mask is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond | input | LANES | Per-lane branch condition, 1 = lane takes the branch |
| branch_i | input | 1 | Branch strobe |
| else_i | input | 1 | Switch-to-other-path strobe |
| conv_i | input | 1 | Convergence strobe |
| active_mask | output | LANES | Current active-lane mask |
| stack_full | output | 1 | Stack holds DEPTH entries |
| stack_empty | output | 1 | Stack holds no entries |
| overflow_err | output | 1 | Sticky: a divergent branch met a full stack |

## Verification
The hardest state to reach from the ports is a full stack followed by one more divergent branch. Reaching it takes eight nested branches, each of which must split an active mask that shrinks every time, so random conditions rarely get there. A directed sequence builds the full stack by dropping only the lowest live lane at each level, hits the overflow, and then unwinds through else and converge. Random phases that favour branches, with conditions drawn from random, all-taken, none-taken and one-lane-dropped patterns, reach the limit again and again. They are mixed with simultaneous strobes and strobes on an empty stack.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_BRANCH,
        REQ_ELSE,
        REQ_CONV
    } stack_req_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_PUSH,
        ACT_FLIP,
        ACT_POP
    } stack_act_e;

    typedef struct packed {
        stack_act_e act;
        logic       ovf_set;
    } stack_cmd_t;

    function automatic stack_req_e pick_request(input logic br, input logic el, input logic cv);
        if (cv)      return REQ_CONV;
        else if (el) return REQ_ELSE;
        else if (br) return REQ_BRANCH;
        else         return REQ_NONE;
    endfunction

endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval #(
    parameter int unsigned LANES = 32
) (
    input  logic [LANES-1:0] active,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] taken,
    output logic             divergent
);
    logic any_taken;
    logic all_taken;

    always_comb begin
        taken     = active & cond;
        any_taken = |taken;
        all_taken = (taken == active);
        divergent = any_taken && !all_taken;
    end
endmodule

// File: rtl/simt_op_decode.sv
module simt_op_decode
    import simt_stack_pkg::*;
(
    input  logic       branch_i,
    input  logic       else_i,
    input  logic       conv_i,
    input  logic       divergent,
    input  logic       empty,
    input  logic       full,
    input  logic       top_in_else,
    output stack_cmd_t cmd
);
    stack_req_e req;

    always_comb begin
        req         = pick_request(branch_i, else_i, conv_i);
        cmd.act     = ACT_HOLD;
        cmd.ovf_set = 1'b0;
        unique case (req)
            REQ_CONV: begin
                if (!empty) cmd.act = ACT_POP;
            end
            REQ_ELSE: begin
                if (!empty && !top_in_else) cmd.act = ACT_FLIP;
            end
            REQ_BRANCH: begin
                if (divergent) begin
                    if (full) cmd.ovf_set = 1'b1;
                    else      cmd.act     = ACT_PUSH;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/simt_mask_lifo.sv
module simt_mask_lifo #(
    parameter int unsigned LANES = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic                     pop,
    input  logic                     flip,
    input  logic [LANES-1:0]         push_saved,
    input  logic [LANES-1:0]         push_taken,
    output logic [LANES-1:0]         top_saved,
    output logic [LANES-1:0]         top_taken,
    output logic                     top_in_else,
    output logic                     full,
    output logic                     empty
);
    localparam int unsigned CNTW = $clog2(DEPTH + 1);
    localparam int unsigned IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNTW-1:0]  count_q;
    logic [IDXW-1:0]  top_idx;
    logic [LANES-1:0] saved_q [DEPTH];
    logic [LANES-1:0] taken_q [DEPTH];
    logic             phase_q [DEPTH];

    assign empty   = (count_q == '0);
    assign full    = (count_q == CNTW'(DEPTH));
    assign top_idx = empty ? '0 : IDXW'(count_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst)       count_q <= '0;
        else if (push) count_q <= count_q + 1'b1;
        else if (pop)  count_q <= count_q - 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic wr_new;
        logic wr_flip;
        assign wr_new  = push && (count_q == CNTW'(i));
        assign wr_flip = flip && !empty && (top_idx == IDXW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                saved_q[i] <= '0;
                taken_q[i] <= '0;
                phase_q[i] <= 1'b0;
            end else if (wr_new) begin
                saved_q[i] <= push_saved;
                taken_q[i] <= push_taken;
                phase_q[i] <= 1'b0;
            end else if (wr_flip) begin
                phase_q[i] <= 1'b1;
            end
        end
    end

    assign top_saved   = saved_q[top_idx];
    assign top_taken   = taken_q[top_idx];
    assign top_in_else = phase_q[top_idx];
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_stack_pkg::*;
#(
    parameter int unsigned LANES = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] cond,
    input  logic             branch_i,
    input  logic             else_i,
    input  logic             conv_i,
    output logic [LANES-1:0] active_mask,
    output logic             stack_full,
    output logic             stack_empty,
    output logic             overflow_err
);
    logic [LANES-1:0] active_q;
    logic [LANES-1:0] active_d;
    logic [LANES-1:0] taken;
    logic             divergent;
    logic [LANES-1:0] top_saved;
    logic [LANES-1:0] top_taken;
    logic             top_in_else;
    logic             ovf_q;
    stack_cmd_t       cmd;

    simt_branch_eval #(.LANES(LANES)) u_eval (
        .active    (active_q),
        .cond      (cond),
        .taken     (taken),
        .divergent (divergent)
    );

    simt_op_decode u_dec (
        .branch_i    (branch_i),
        .else_i      (else_i),
        .conv_i      (conv_i),
        .divergent   (divergent),
        .empty       (stack_empty),
        .full        (stack_full),
        .top_in_else (top_in_else),
        .cmd         (cmd)
    );

    simt_mask_lifo #(.LANES(LANES), .DEPTH(DEPTH)) u_lifo (
        .clk         (clk),
        .rst         (rst),
        .push        (cmd.act == ACT_PUSH),
        .pop         (cmd.act == ACT_POP),
        .flip        (cmd.act == ACT_FLIP),
        .push_saved  (active_q),
        .push_taken  (taken),
        .top_saved   (top_saved),
        .top_taken   (top_taken),
        .top_in_else (top_in_else),
        .full        (stack_full),
        .empty       (stack_empty)
    );

    always_comb begin
        unique case (cmd.act)
            ACT_PUSH: active_d = taken;
            ACT_FLIP: active_d = top_saved & ~top_taken;
            ACT_POP:  active_d = top_saved;
            default:  active_d = active_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '1;
            ovf_q    <= 1'b0;
        end else begin
            active_q <= active_d;
            if (cmd.ovf_set) ovf_q <= 1'b1;
        end
    end

    assign active_mask  = active_q;
    assign overflow_err = ovf_q;
endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
    parameter int unsigned LANES = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] cond,
    input logic             branch_i,
    input logic             else_i,
    input logic             conv_i,
    input logic [LANES-1:0] active_mask,
    input logic             stack_full,
    input logic             stack_empty,
    input logic             overflow_err
);
    logic br_only;
    logic splits;
    assign br_only = branch_i && !else_i && !conv_i;
    assign splits  = ((active_mask & cond) != '0) && ((active_mask & cond) != active_mask);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (active_mask == '1 && stack_empty && !stack_full && !overflow_err));

    p_diverge_narrow_r2: assert property (@(posedge clk) disable iff (rst)
        (br_only && splits && !stack_full) |=> (active_mask == $past(active_mask & cond)) && !stack_empty);

    p_uniform_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (br_only && !splits) |=> $stable(active_mask));

    p_pop_frees_r5: assert property (@(posedge clk) disable iff (rst)
        (conv_i && !stack_empty) |=> !stack_full);

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(stack_full && stack_empty));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (br_only && splits && stack_full) |=> $stable(active_mask) && stack_full && overflow_err);

    p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        overflow_err |=> overflow_err);

    p_empty_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        ((conv_i || else_i) && stack_empty) |=> $stable(active_mask) && stack_empty);

    p_mask_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
        active_mask != '0);
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cond         (cond),
    .branch_i     (branch_i),
    .else_i       (else_i),
    .conv_i       (conv_i),
    .active_mask  (active_mask),
    .stack_full   (stack_full),
    .stack_empty  (stack_empty),
    .overflow_err (overflow_err)
);

// File: tb/simt_mask_stack_bench.sv
module simt_mask_stack_bench;
    localparam int unsigned LANES  = 32;
    localparam int unsigned DEPTH  = 8;
    localparam int unsigned PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] cond = '0;
    logic             branch_i = 1'b0;
    logic             else_i = 1'b0;
    logic             conv_i = 1'b0;
    logic [LANES-1:0] active_mask;
    logic             stack_full;
    logic             stack_empty;
    logic             overflow_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [LANES-1:0] m_active;
    logic [LANES-1:0] m_saved [DEPTH];
    logic [LANES-1:0] m_taken [DEPTH];
    bit               m_else  [DEPTH];
    int               m_cnt;
    bit               m_ovf;

    always #(PERIOD/2) clk = ~clk;

    simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_simt_mask_stack (
        .clk(clk), .rst(rst), .cond(cond), .branch_i(branch_i), .else_i(else_i),
        .conv_i(conv_i), .active_mask(active_mask), .stack_full(stack_full),
        .stack_empty(stack_empty), .overflow_err(overflow_err)
    );

    function automatic logic [LANES-1:0] drop_low(input logic [LANES-1:0] m);
        return m & (m - 1'b1);
    endfunction

    function automatic string classify(input bit br, input bit el, input bit cv,
                                       input logic [LANES-1:0] c);
        logic [LANES-1:0] t;
        if (cv) return (m_cnt > 0) ? "R5" : "R8";
        if (el) return (m_cnt > 0) ? "R4" : "R8";
        if (br) begin
            t = m_active & c;
            if (t == '0 || t == m_active) return "R3";
            return (m_cnt == DEPTH) ? "R7" : "R2";
        end
        return "R10";
    endfunction

    task automatic model_step(input bit br, input bit el, input bit cv, input logic [LANES-1:0] c);
        logic [LANES-1:0] t;
        if (cv) begin
            if (m_cnt > 0) begin
                m_cnt--;
                m_active = m_saved[m_cnt];
            end
        end else if (el) begin
            if (m_cnt > 0 && !m_else[m_cnt-1]) begin
                m_active = m_saved[m_cnt-1] & ~m_taken[m_cnt-1];
                m_else[m_cnt-1] = 1'b1;
            end
        end else if (br) begin
            t = m_active & c;
            if (t != '0 && t != m_active) begin
                if (m_cnt == DEPTH) m_ovf = 1'b1;
                else begin
                    m_saved[m_cnt] = m_active;
                    m_taken[m_cnt] = t;
                    m_else[m_cnt]  = 1'b0;
                    m_cnt++;
                    m_active = t;
                end
            end
        end
    endtask

    task automatic chk(input string req, input string what, input logic [LANES-1:0] act,
                       input logic [LANES-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "active_mask", active_mask, m_active);
        chk((req == "R2" || req == "R5") ? "R6" : req, "stack_full",
            {31'b0, stack_full}, {31'b0, (m_cnt == DEPTH)});
        chk((req == "R2" || req == "R5") ? "R6" : req, "stack_empty",
            {31'b0, stack_empty}, {31'b0, (m_cnt == 0)});
        chk(req == "R7" ? "R7" : req, "overflow_err", {31'b0, overflow_err}, {31'b0, m_ovf});
        if (!rst) chk("R10", "mask_nonzero", {31'b0, (active_mask != '0)}, 32'd1);
    endtask

    task automatic step(input bit br, input bit el, input bit cv, input logic [LANES-1:0] c,
                        input string force_req);
        string req;
        @(negedge clk);
        branch_i = br; else_i = el; conv_i = cv; cond = c;
        req = (force_req != "") ? force_req : classify(br, el, cv, c);
        model_step(br, el, cv, c);
        @(posedge clk);
        #1;
        check_all(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; branch_i = 0; else_i = 0; conv_i = 0; cond = '0;
        repeat (2) @(posedge clk);
        #1;
        m_active = '1; m_cnt = 0; m_ovf = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            m_saved[i] = '0; m_taken[i] = '0; m_else[i] = 1'b0;
        end
        check_all("R1");
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [LANES-1:0] c;
        int r;
        void'($urandom(32'h5EED_0042));
        do_reset();

        // R2 divergent, R4 else, R4 repeated else ignored, R5 converge
        step(1, 0, 0, 32'h0000_FFFF, "R2");
        step(0, 1, 0, '0, "R4");
        chk("R4", "else_half_disjoint", active_mask & 32'h0000_FFFF, '0);
        step(0, 1, 0, '0, "R4");
        step(0, 0, 1, '0, "R5");
        // R3 uniform: all taken, none taken
        step(1, 0, 0, '1, "R3");
        step(1, 0, 0, '0, "R3");
        // R8 strobes on empty stack
        step(0, 1, 0, '0, "R8");
        step(0, 0, 1, '0, "R8");
        // R9 priority: converge beats branch on empty stack, else beats branch
        step(1, 0, 1, 32'h0000_00FF, "R9");
        step(1, 0, 0, 32'h0000_00FF, "R2");
        step(1, 1, 0, 32'h0000_000F, "R9");
        step(1, 1, 1, 32'h0000_0003, "R9");
        // R6 fill to depth, R7 overflow
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, drop_low(m_active), "R6");
        step(1, 0, 0, drop_low(m_active), "R7");
        step(0, 0, 0, '0, "R7");
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 1, 0, '0, "R4");
            step(0, 0, 1, '0, "R5");
        end
        do_reset();

        // random phases
        for (int n = 0; n < 3000; n++) begin
            r = $urandom_range(0, 3);
            case (r)
                0: c = $urandom();
                1: c = '1;
                2: c = '0;
                default: c = drop_low(m_active);
            endcase
            r = $urandom_range(0, 99);
            if (((n / 200) % 2) == 0) begin
                if (r < 70)      step(1, 0, 0, c, "");
                else if (r < 80) step(0, 1, 0, c, "");
                else if (r < 90) step(0, 0, 1, c, "");
                else             step(r[0], r[1], r[2], c, "R9");
            end else begin
                if (r < 20)      step(1, 0, 0, c, "");
                else if (r < 50) step(0, 1, 0, c, "");
                else if (r < 90) step(0, 0, 1, c, "");
                else             step(r[0], r[1], r[2], c, "R9");
            end
            if (n == 1500) do_reset();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule